// File: doc/BRIEF.md
# Complex Vector MAC Unit

This execution unit carries out one whole complex vector operation for each instruction it accepts. The vector may be of any length, and that length is not tied to the width of the datapath. The issuing controller hands over a short instruction word that holds an operation bit, a conjugate bit and a length. The unit's own sequencer then counts the vector through a two-lane complex datapath. During that time the controller can go on issuing instructions to other units. Operand samples come in on two memory-side streams, A and B. Address and twiddle generation happen upstream, so twiddles are simply part of the B stream. Results leave on a single output stream.

In dot mode the unit forms the complex scalar product of two vectors, or a·conj(b) when the conjugate bit is set. It processes two element pairs per beat, keeps one wide accumulator per lane and emits the sum of the two lanes once at the end. In butterfly mode the same multipliers are used to compute a ± round(w·b), one butterfly per beat. The product is rounded back to 16 bits and both outputs are saturated. The A, B and output interfaces are valid/ready streams. A transfer happens on a rising clock edge where valid and ready are both high. A valid that has been raised stays high, with stable data, until it is taken. A and B are consumed together. The instruction port uses a plain valid/ready pair, and `busy` and `done` are plain status pins.

Top module: `cvec_mac_unit`

## Requirements
- R1: An instruction {instr_op, instr_conj, instr_len} is taken on a rising edge with instr_valid and instr_ready both high. instr_ready equals not busy. While busy is high, a held-up instruction is not taken and does not change the running operation.
- R2: With instr_op = 0 (dot), the single result has out_x_re/out_x_im equal to the exact sum over k < len of a_k·b_k, sign-extended to ACC_W bits. out_y_re and out_y_im are zero and out_last is 1.
- R3: In dot mode each beat carries elements 2j (lane 0, bits [31:0]) and 2j+1 (lane 1, bits [63:32]). Each lane holds re in its low 16 bits and im in its high 16 bits. Exactly ceil(len/2) beats are consumed, and A and B transfer only together.
- R4: For an odd dot length, the lane 1 samples of the final beat have no effect on the result.
- R5: With instr_op = 1 (butterfly), each beat carries a in A lane 0, b in A lane 1 and w in B lane 0, and B lane 1 is ignored. One result is produced per beat, in order, with x = a + w·b, y = a − w·b, and out_last set only on the final one.
- R6: The butterfly product is reduced to Q15 by round-half-up: floor((p + 2^14) / 2^15).
- R7: Each butterfly output part is saturated to the range [−32768, 32767].
- R8: While out_valid is high and out_ready is low, all out_* pins hold their values. In butterfly mode no new beat is consumed until the output register can accept it.
- R9: done is high for exactly one cycle. That cycle is the first one in which the final result is presented, and busy is already low in it.
- R10: A length of 0 finishes with a done pulse. Dot mode then gives one result of zero, and butterfly mode gives no result.
- R11: With instr_conj = 1, the B-stream operand is conjugated: dot gives Σ a·conj(b), and butterfly uses conj(w).
- R12: After reset, busy, done and out_valid are low and instr_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit idle, instruction can be taken |
| instr_op | input | 1 | 0 = dot product, 1 = butterfly pass |
| instr_conj | input | 1 | Conjugate the B-stream operand |
| instr_len | input | LEN_W | Element count (dot) or butterfly count |
| busy | output | 1 | Vector operation in progress |
| done | output | 1 | One-cycle completion pulse |
| a_valid | input | 1 | A stream beat valid |
| a_ready | output | 1 | A stream beat accepted |
| a_data | input | 64 | Two complex 16-bit samples |
| b_valid | input | 1 | B stream beat valid |
| b_ready | output | 1 | B stream beat accepted |
| b_data | input | 64 | Two complex 16-bit samples |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result accepted |
| out_last | output | 1 | Final result of the instruction |
| out_x_re | output | ACC_W | Dot sum real / butterfly upper real |
| out_x_im | output | ACC_W | Dot sum imag / butterfly upper imag |
| out_y_re | output | ACC_W | Zero / butterfly lower real |
| out_y_im | output | ACC_W | Zero / butterfly lower imag |

## Verification
The hardest state to reach from the ports is a butterfly stream that stalls in the middle of the vector. In that state the output register is full, both input streams are offering a beat, and no beat is allowed to transfer. Reaching it needs independent random gaps on A and B together with random back-pressure on the output. The bench drives all three from separate pseudo-random sequences for each instruction length. It then checks that every held result stays stable and that the result sequence matches its arithmetic model exactly. The odd-length tail and the saturation and rounding corners are reached by placing a non-zero value in the unused lane and by loading full-scale and half-LSB operands.

// File: rtl/cvec_pkg.sv
package cvec_pkg;
  localparam int SAMP_W = 16;
  localparam int LANES  = 2;
  localparam int CPLX_W = 2 * SAMP_W;
  localparam int PROD_W = 2 * SAMP_W + 2;

  typedef enum logic {
    OP_DOT  = 1'b0,
    OP_BFLY = 1'b1
  } vop_e;

  typedef struct packed {
    logic signed [SAMP_W-1:0] im;
    logic signed [SAMP_W-1:0] re;
  } cplx_t;
endpackage

// File: rtl/cvec_cmul.sv
module cvec_cmul
  import cvec_pkg::*;
(
  input  cplx_t                    x,
  input  cplx_t                    y,
  input  logic                     conj,
  output logic signed [PROD_W-1:0] p_re,
  output logic signed [PROD_W-1:0] p_im
);
  logic signed [2*SAMP_W-1:0] rr, ii, ri, ir;
  logic signed [PROD_W-1:0]   rr_w, ii_w, ri_w, ir_w;

  assign rr = x.re * y.re;
  assign ii = x.im * y.im;
  assign ri = x.re * y.im;
  assign ir = x.im * y.re;

  assign rr_w = PROD_W'(rr);
  assign ii_w = PROD_W'(ii);
  assign ri_w = PROD_W'(ri);
  assign ir_w = PROD_W'(ir);

  // conj(y) flips the sign of y.im in both partial sums
  always_comb begin
    if (conj) begin
      p_re = rr_w + ii_w;
      p_im = ir_w - ri_w;
    end else begin
      p_re = rr_w - ii_w;
      p_im = ir_w + ri_w;
    end
  end
endmodule

// File: rtl/cvec_bfly_post.sv
module cvec_bfly_post
  import cvec_pkg::*;
(
  input  cplx_t                    a,
  input  logic signed [PROD_W-1:0] p_re,
  input  logic signed [PROD_W-1:0] p_im,
  output cplx_t                    x,
  output cplx_t                    y
);
  localparam int RSH = SAMP_W - 1;
  localparam int R_W = PROD_W - RSH;
  localparam int S_W = R_W + 1;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (RSH - 1);

  logic signed [PROD_W-1:0] b_re, b_im;
  logic signed [R_W-1:0]    r_re, r_im;
  logic signed [S_W-1:0]    s_xr, s_xi, s_yr, s_yi;

  function automatic logic signed [SAMP_W-1:0] clip(input logic signed [S_W-1:0] v);
    logic [S_W-SAMP_W:0] top;
    top = v[S_W-1:SAMP_W-1];
    if ((&top) || !(|top)) return v[SAMP_W-1:0];
    else if (v[S_W-1])     return {1'b1, {(SAMP_W-1){1'b0}}};
    else                   return {1'b0, {(SAMP_W-1){1'b1}}};
  endfunction

  assign b_re = p_re + HALF;
  assign b_im = p_im + HALF;
  assign r_re = b_re[PROD_W-1:RSH];
  assign r_im = b_im[PROD_W-1:RSH];

  assign s_xr = S_W'(a.re) + S_W'(r_re);
  assign s_xi = S_W'(a.im) + S_W'(r_im);
  assign s_yr = S_W'(a.re) - S_W'(r_re);
  assign s_yi = S_W'(a.im) - S_W'(r_im);

  assign x.re = clip(s_xr);
  assign x.im = clip(s_xi);
  assign y.re = clip(s_yr);
  assign y.im = clip(s_yi);
endmodule

// File: rtl/cvec_ctrl.sv
module cvec_ctrl
  import cvec_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  vop_e             instr_op,
  input  logic             instr_conj,
  input  logic [LEN_W-1:0] instr_len,
  input  logic             fire,
  input  logic             slot_ok,
  output logic             instr_ready,
  output logic             busy,
  output logic             start,
  output logic             run,
  output logic             fin,
  output logic             last_beat,
  output logic             odd_tail,
  output logic             finish,
  output vop_e             op_q,
  output logic             conj_q
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

  st_e              st;
  logic [LEN_W-1:0] rem;
  logic [LEN_W:0]   len_p1;
  logic [LEN_W-1:0] beats;

  assign len_p1 = (LEN_W+1)'(instr_len) + (LEN_W+1)'(1);
  assign beats  = (instr_op == OP_DOT) ? len_p1[LEN_W:1] : instr_len;

  assign busy        = (st != ST_IDLE);
  assign instr_ready = !busy;
  assign start       = instr_valid && instr_ready;
  assign run         = (st == ST_RUN);
  assign fin         = (st == ST_FIN);
  assign last_beat   = (rem == LEN_W'(1));
  assign finish      = (run && fire && last_beat && op_q == OP_BFLY) ||
                       (fin && (op_q == OP_BFLY || slot_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      rem      <= '0;
      op_q     <= OP_DOT;
      conj_q   <= 1'b0;
      odd_tail <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          op_q     <= instr_op;
          conj_q   <= instr_conj;
          odd_tail <= (instr_op == OP_DOT) && instr_len[0];
          rem      <= beats;
          st       <= (beats == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: if (fire) begin
          rem <= rem - LEN_W'(1);
          if (last_beat) st <= (op_q == OP_DOT) ? ST_FIN : ST_IDLE;
        end
        default: if (finish) st <= ST_IDLE;
      endcase
    end
  end

  // R3
  rem_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rem != '0));
  // R3
  fin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !fire);
endmodule

// File: rtl/cvec_mac_unit.sv
module cvec_mac_unit
  import cvec_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int ACC_W = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     instr_valid,
  output logic                     instr_ready,
  input  logic                     instr_op,
  input  logic                     instr_conj,
  input  logic [LEN_W-1:0]         instr_len,
  output logic                     busy,
  output logic                     done,
  input  logic                     a_valid,
  output logic                     a_ready,
  input  logic [LANES*CPLX_W-1:0]  a_data,
  input  logic                     b_valid,
  output logic                     b_ready,
  input  logic [LANES*CPLX_W-1:0]  b_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_last,
  output logic signed [ACC_W-1:0]  out_x_re,
  output logic signed [ACC_W-1:0]  out_x_im,
  output logic signed [ACC_W-1:0]  out_y_re,
  output logic signed [ACC_W-1:0]  out_y_im
);
  logic start, run, fin, last_beat, odd_tail, finish, conj_q;
  logic slot_ok, run_ok, fire, load_bf, load_dot;
  vop_e op_q;

  cplx_t                    a_lane [LANES];
  cplx_t                    b_lane [LANES];
  logic signed [PROD_W-1:0] p_re   [LANES];
  logic signed [PROD_W-1:0] p_im   [LANES];
  logic signed [ACC_W-1:0]  acc_re [LANES];
  logic signed [ACC_W-1:0]  acc_im [LANES];
  logic signed [ACC_W-1:0]  sum_re, sum_im;
  cplx_t                    bf_x, bf_y;

  cvec_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_valid(instr_valid),
    .instr_op   (vop_e'(instr_op)),
    .instr_conj (instr_conj),
    .instr_len  (instr_len),
    .fire       (fire),
    .slot_ok    (slot_ok),
    .instr_ready(instr_ready),
    .busy       (busy),
    .start      (start),
    .run        (run),
    .fin        (fin),
    .last_beat  (last_beat),
    .odd_tail   (odd_tail),
    .finish     (finish),
    .op_q       (op_q),
    .conj_q     (conj_q)
  );

  // stream handshake: A and B move together, butterfly needs a free output slot
  assign slot_ok = !out_valid || out_ready;
  assign run_ok  = run && (op_q == OP_DOT || slot_ok);
  assign a_ready = run_ok && b_valid;
  assign b_ready = run_ok && a_valid;
  assign fire    = run_ok && a_valid && b_valid;

  for (genvar l = 0; l < LANES; l++) begin : g_unpack
    assign a_lane[l] = a_data[l*CPLX_W +: CPLX_W];
    assign b_lane[l] = b_data[l*CPLX_W +: CPLX_W];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    cplx_t                    x_in;
    logic signed [PROD_W-1:0] m_re, m_im;
    logic                     keep;

    if (l == 0) begin : g_xsel
      assign x_in = (op_q == OP_BFLY) ? a_lane[1] : a_lane[0];
    end else begin : g_xdir
      assign x_in = a_lane[l];
    end

    assign keep = !((l == LANES-1) && odd_tail && last_beat);

    cvec_cmul u_mul (
      .x   (x_in),
      .y   (b_lane[l]),
      .conj(conj_q),
      .p_re(m_re),
      .p_im(m_im)
    );

    assign p_re[l] = keep ? m_re : '0;
    assign p_im[l] = keep ? m_im : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++) begin
        acc_re[l] <= '0;
        acc_im[l] <= '0;
      end
    end else if (start) begin
      for (int l = 0; l < LANES; l++) begin
        acc_re[l] <= '0;
        acc_im[l] <= '0;
      end
    end else if (fire && op_q == OP_DOT) begin
      for (int l = 0; l < LANES; l++) begin
        acc_re[l] <= acc_re[l] + ACC_W'(p_re[l]);
        acc_im[l] <= acc_im[l] + ACC_W'(p_im[l]);
      end
    end
  end

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int l = 0; l < LANES; l++) begin
      sum_re = sum_re + acc_re[l];
      sum_im = sum_im + acc_im[l];
    end
  end

  cvec_bfly_post u_post (
    .a   (a_lane[0]),
    .p_re(p_re[0]),
    .p_im(p_im[0]),
    .x   (bf_x),
    .y   (bf_y)
  );

  assign load_bf  = fire && (op_q == OP_BFLY);
  assign load_dot = fin && (op_q == OP_DOT) && slot_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_x_re  <= '0;
      out_x_im  <= '0;
      out_y_re  <= '0;
      out_y_im  <= '0;
      done      <= 1'b0;
    end else begin
      done <= finish;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (load_bf) begin
        out_valid <= 1'b1;
        out_last  <= last_beat;
        out_x_re  <= ACC_W'(bf_x.re);
        out_x_im  <= ACC_W'(bf_x.im);
        out_y_re  <= ACC_W'(bf_y.re);
        out_y_im  <= ACC_W'(bf_y.im);
      end else if (load_dot) begin
        out_valid <= 1'b1;
        out_last  <= 1'b1;
        out_x_re  <= sum_re;
        out_x_im  <= sum_im;
        out_y_re  <= '0;
        out_y_im  <= '0;
      end
    end
  end

  // R1
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !instr_ready);
  // R3
  joint_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready) |-> (b_valid && b_ready));
  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x_re) && $stable(out_x_im)
                                   && $stable(out_y_re) && $stable(out_y_im) && $stable(out_last)));
  // R8
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && op_q == OP_BFLY) |-> !a_ready);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/tb_cvec_mac_unit.sv
`timescale 1ns/1ps
module tb_cvec_mac_unit;
  localparam int LEN_W = 16;
  localparam int ACC_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0, instr_op = 1'b0, instr_conj = 1'b0;
  logic [LEN_W-1:0] instr_len = '0;
  logic instr_ready, busy, done;
  logic a_valid = 1'b0, b_valid = 1'b0, out_ready = 1'b1;
  logic a_ready, b_ready, out_valid, out_last;
  logic [63:0] a_data = '0, b_data = '0;
  logic signed [ACC_W-1:0] out_x_re, out_x_im, out_y_re, out_y_im;

  cvec_mac_unit #(.LEN_W(LEN_W), .ACC_W(ACC_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_op(instr_op),
    .instr_conj(instr_conj), .instr_len(instr_len), .busy(busy), .done(done),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .out_x_re(out_x_re), .out_x_im(out_x_im), .out_y_re(out_y_re), .out_y_im(out_y_im)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic signed [15:0] ar[64], ai[64], br[64], bi[64], wr[64], wi[64];
  longint exr[64], exi[64], eyr[64], eyi[64];
  logic [31:0] dseed = 32'h1234_5678, fseed = 32'h0bad_cafe, cseed = 32'h7777_0101;
  bit bp_en = 1'b0;
  bit stop_feed;
  int fed;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    s ^= s << 13;
    s ^= s >> 17;
    s ^= s << 5;
    return s;
  endfunction

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic fill_rand();
    for (int k = 0; k < 64; k++) begin
      dseed = xs(dseed); ar[k] = dseed[15:0]; ai[k] = dseed[31:16];
      dseed = xs(dseed); br[k] = dseed[15:0]; bi[k] = dseed[31:16];
      dseed = xs(dseed); wr[k] = dseed[15:0]; wi[k] = dseed[31:16];
      if (k % 5 == 0) begin ar[k] = -16'sd32768; br[k] = -16'sd32768; end
    end
  endtask

  task automatic compute_exp(input bit op, input bit conj, input int len);
    longint sr, si, pr, pi, rr, ri;
    if (!op) begin
      sr = 0; si = 0;
      for (int k = 0; k < len; k++) begin
        if (conj) begin
          pr = longint'(ar[k])*br[k] + longint'(ai[k])*bi[k];
          pi = longint'(ai[k])*br[k] - longint'(ar[k])*bi[k];
        end else begin
          pr = longint'(ar[k])*br[k] - longint'(ai[k])*bi[k];
          pi = longint'(ai[k])*br[k] + longint'(ar[k])*bi[k];
        end
        sr += pr; si += pi;
      end
      exr[0] = sr; exi[0] = si; eyr[0] = 0; eyi[0] = 0;
    end else begin
      for (int j = 0; j < len; j++) begin
        if (conj) begin
          pr = longint'(br[j])*wr[j] + longint'(bi[j])*wi[j];
          pi = longint'(bi[j])*wr[j] - longint'(br[j])*wi[j];
        end else begin
          pr = longint'(br[j])*wr[j] - longint'(bi[j])*wi[j];
          pi = longint'(br[j])*wi[j] + longint'(bi[j])*wr[j];
        end
        rr = (pr + 16384) >>> 15;
        ri = (pi + 16384) >>> 15;
        exr[j] = sat16(ar[j] + rr); exi[j] = sat16(ai[j] + ri);
        eyr[j] = sat16(ar[j] - rr); eyi[j] = sat16(ai[j] - ri);
      end
    end
  endtask

  task automatic feed(input bit op, input int len);
    int nb, idx;
    bit took;
    nb = op ? len : (len + 1) / 2;
    idx = 0; took = 0;
    while (idx < nb && !stop_feed) begin
      @(negedge clk);
      if (took) begin a_valid = 0; b_valid = 0; took = 0; end
      if (idx < nb) begin
        if (!op) begin
          a_data[31:0] = {ai[2*idx], ar[2*idx]};
          b_data[31:0] = {bi[2*idx], br[2*idx]};
          if (2*idx + 1 < len) begin
            a_data[63:32] = {ai[2*idx+1], ar[2*idx+1]};
            b_data[63:32] = {bi[2*idx+1], br[2*idx+1]};
          end else begin
            a_data[63:32] = 32'h5a5a_7abc;   // R4 junk in unused lane
            b_data[63:32] = 32'h3c3c_6def;
          end
        end else begin
          a_data = {bi[idx], br[idx], ai[idx], ar[idx]};
          b_data = {32'h7fff_7fff, wi[idx], wr[idx]};  // R5 lane 1 of B ignored
        end
        if (!a_valid) begin fseed = xs(fseed); a_valid = !bp_en || (fseed[1:0] != 0); end
        if (!b_valid) begin fseed = xs(fseed); b_valid = !bp_en || (fseed[3:2] != 0); end
        #1;
        if (a_valid && a_ready && b_valid && b_ready) begin took = 1; idx++; end
      end
    end
    @(negedge clk);
    a_valid = 0; b_valid = 0;
    fed = idx;
  endtask

  task automatic collect(input bit op, input int len, input string tag);
    int nexp, got;
    bit dseen, stall;
    longint hxr, hxi, hyr, hyi;
    nexp = op ? len : 1;
    got = 0; dseen = 0; stall = 0;
    hxr = 0; hxi = 0; hyr = 0; hyi = 0;
    while (!(dseen && got == nexp)) begin
      @(negedge clk);
      if (bp_en) begin cseed = xs(cseed); out_ready = (cseed[1:0] != 0); end
      else out_ready = 1;
      instr_valid = busy;          // R1 held-up instruction while busy
      instr_op = ~op; instr_len = 5;
      if (busy) chk(!instr_ready, "R1", instr_ready, 0);
      if (stall) chk(out_valid && longint'(out_x_re) == hxr && longint'(out_x_im) == hxi &&
                     longint'(out_y_re) == hyr && longint'(out_y_im) == hyi, "R8",
                     longint'(out_x_re), hxr);
      if (done) begin
        dseen = 1;
        chk(!busy, "R9", busy, 0);
        if (nexp == 0) chk(!out_valid, "R10", out_valid, 0);
        else chk(out_valid && out_last && got == nexp - 1, "R9", got, nexp - 1);
      end
      if (out_valid && out_ready) begin
        if (got < nexp) begin
          chk(longint'(out_x_re) == exr[got], tag, longint'(out_x_re), exr[got]);
          chk(longint'(out_x_im) == exi[got], tag, longint'(out_x_im), exi[got]);
          chk(longint'(out_y_re) == eyr[got], tag, longint'(out_y_re), eyr[got]);
          chk(longint'(out_y_im) == eyi[got], tag, longint'(out_y_im), eyi[got]);
          chk(out_last == (got == nexp - 1), "R5", out_last, (got == nexp - 1));
        end else chk(0, "R5", got + 1, nexp);
        got++;
      end
      stall = out_valid && !out_ready;
      hxr = out_x_re; hxi = out_x_im; hyr = out_y_re; hyi = out_y_im;
    end
    instr_valid = 0;
    @(negedge clk);
    chk(!done, "R9", done, 0);
    out_ready = 1;
  endtask

  task automatic run(input bit op, input bit conj, input int len, input string tag);
    int nb;
    nb = op ? len : (len + 1) / 2;
    compute_exp(op, conj, len);
    @(negedge clk);
    chk(instr_ready, "R1", instr_ready, 1);
    instr_valid = 1; instr_op = op; instr_conj = conj; instr_len = LEN_W'(len);
    #1;
    while (!instr_ready) begin @(negedge clk); #1; end
    stop_feed = 0;
    fork
      feed(op, len);
      begin collect(op, len, tag); stop_feed = 1; end
    join
    chk(fed == nb, "R3", fed, nb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(instr_ready && !busy, "R12", busy, 0);
    chk(!out_valid && !done, "R12", out_valid, 0);

    fill_rand();
    bp_en = 0;
    for (int n = 1; n <= 4; n++) run(0, 0, n, "R2");
    bp_en = 1;
    for (int n = 0; n <= 9; n++) begin
      run(0, 0, n, (n == 0) ? "R10" : ((n % 2) ? "R4" : "R2"));
      run(0, 1, n, "R11");
    end
    for (int n = 0; n <= 6; n++) begin
      fill_rand();
      run(1, 0, n, (n == 0) ? "R10" : "R5");
      run(1, 1, n, "R11");
    end
    // corners: saturation both ways, half-LSB rounding, full-scale product
    ar[0] = 16'sd32767;  ai[0] = -16'sd32768; br[0] = 16'sd32767;  bi[0] = 16'sd32767;
    wr[0] = 16'sd32767;  wi[0] = 16'sd0;
    ar[1] = 16'sd100;    ai[1] = -16'sd100;   br[1] = 16'sd1;      bi[1] = -16'sd1;
    wr[1] = 16'sd16384;  wi[1] = 16'sd0;
    ar[2] = 16'sd0;      ai[2] = 16'sd0;      br[2] = -16'sd32768; bi[2] = -16'sd32768;
    wr[2] = -16'sd32768; wi[2] = 16'sd0;
    ar[3] = 16'sd5;      ai[3] = 16'sd7;      br[3] = 16'sd3;      bi[3] = 16'sd0;
    wr[3] = 16'sd5461;   wi[3] = -16'sd5461;
    run(1, 0, 4, "R7");
    run(1, 1, 4, "R6");
    bp_en = 0;
    run(1, 0, 4, "R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule